// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Source

This block takes interrupt requests from five sources, INT0 to INT4, and feeds a small 8-bit core. Each request line is latched as pending on a rising edge. A pending source becomes eligible when it is enabled and nothing blocks it. The eligible source with the lowest number wins. The block then raises a take strobe toward the core together with the winner's vector address. The pending bit of the winner clears on the clock edge that ends the take cycle.

INT0 is non-maskable. Its enable bit is ignored, and the in-service flag that stops the other sources from nesting does not block it. A system-mode input holds off every source while privileged code runs, INT0 included, and pending bits are kept until the input drops. The block also drives the start address that the core fetches after reset. That address depends on whether the part runs from its battery or from the field supply.

Top module: `vic_top`

## Requirements
- R1: A pending bit is set only when its request line was low on the previous clock edge and is high on the current one. A line that stays high sets nothing more. A line that is high when reset is released counts as already seen and sets nothing.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the enable register at the clock edge, with bit n enabling INTn. Reset clears the register. A source that is pending but disabled stays pending, and it is taken once it is enabled.
- R3: A pending INT0 is taken whenever `sys_mode` is low, whatever its enable bit and whatever `in_service` is.
- R4: When several sources are eligible, the one with the lowest number is taken. At most one source is taken per cycle.
- R5: While `take` is high, `vec_addr` equals 0x0002 + 2*n, where n is the number of the source taken.
- R6: The pending bit of the source taken clears at the clock edge that ends the take cycle. If a new rising edge on that same line is latched at that edge, the bit stays set.
- R7: While `sys_mode` is high, `take` stays low for every source, INT0 included. All pending bits are kept and are served after `sys_mode` falls.
- R8: While `in_service` is high, INT1 to INT4 are not taken.
- R9: `boot_addr` is 0x0000 while `batt_mode` is high and 0x0010 while it is low.
- R10: After reset, `take` is low, no source is pending and all enables are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq | input | 5 | Request lines, bit n is INTn |
| cfg_we | input | 1 | Write strobe for the enable register |
| cfg_wdata | input | 5 | Enable bits to load, bit n is INTn |
| sys_mode | input | 1 | Privileged code running: block all sources |
| in_service | input | 1 | A handler is active: block INT1 to INT4 |
| batt_mode | input | 1 | Supply selector for the start address |
| take | output | 1 | The core should take the vector this cycle |
| vec_addr | output | 16 | Vector address of the source taken |
| boot_addr | output | 16 | Start address after reset |

## Verification
The case that needs care is a take and a new request on the same line landing in the same cycle. The vector is taken, so the pending bit is cleared, and at the same clock edge a fresh rising edge on that line is latched. The bench provokes this by holding a request back with `in_service`, toggling the line low, then dropping `in_service` and raising the line again in one cycle. It judges the result by the second take that must follow. The sweeps over every enable mask and request pattern also land enable writes and takes in the same cycle. A bench model updates its pending state from the same clear-then-set order and predicts every take and vector.

// File: rtl/vic_pkg.sv
package vic_pkg;

   // Address of vector slot idx in a table starting at base with a fixed stride.
   function automatic int unsigned slot_addr(input int unsigned base,
                                             input int unsigned stride,
                                             input int unsigned idx);
      return base + stride * idx;
   endfunction

   // True when v is a non-zero power of two.
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/vic_pend.sv
module vic_pend #(
   parameter int NSRC = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] irq,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] pend
);

   logic [NSRC-1:0] irq_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q[i] <= 1'b1;
            pend[i]  <= 1'b0;
         end else begin
            irq_q[i] <= irq[i];
            pend[i]  <= (pend[i] & ~clr[i]) | (irq[i] & ~irq_q[i]);
         end
      end
   end

endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
   parameter int NSRC    = 5,
   parameter bit HAS_NMI = 1'b1,
   localparam int IDX_W  = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]  pend,
   input  logic [NSRC-1:0]  en,
   input  logic             sys_mode,
   input  logic             in_service,
   output logic             take,
   output logic [NSRC-1:0]  grant,
   output logic [IDX_W-1:0] gidx
);

   localparam logic NMI_ON = HAS_NMI;

   logic [NSRC-1:0] elig;

   // Source 0 ignores its enable and the in-service flag when it is the NMI.
   assign elig[0] = pend[0] & ~sys_mode & (en[0] | NMI_ON) & (~in_service | NMI_ON);

   for (genvar i = 1; i < NSRC; i++) begin : g_elig
      assign elig[i] = pend[i] & en[i] & ~sys_mode & ~in_service;
   end

   always_comb begin
      grant = '0;
      gidx  = '0;
      take  = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         if (!take && elig[i]) begin
            grant[i] = 1'b1;
            gidx     = IDX_W'(i);
            take     = 1'b1;
         end
      end
   end

endmodule

// File: rtl/vic_addr.sv
module vic_addr #(
   parameter int NSRC       = 5,
   parameter int ADDR_W     = 16,
   parameter int VEC_BASE   = 2,
   parameter int VEC_STRIDE = 2,
   parameter int BOOT_BATT  = 0,
   parameter int BOOT_XPDR  = 16,
   localparam int IDX_W     = $clog2(NSRC)
) (
   input  logic [IDX_W-1:0]  gidx,
   input  logic              batt_mode,
   output logic [ADDR_W-1:0] vec_addr,
   output logic [ADDR_W-1:0] boot_addr
);

   localparam int SHIFT = $clog2(VEC_STRIDE);

   if (vic_pkg::is_pow2(VEC_STRIDE)) begin : g_shift
      assign vec_addr = ADDR_W'(VEC_BASE) + (ADDR_W'(gidx) << SHIFT);
   end else begin : g_mult
      assign vec_addr = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(gidx);
   end

   assign boot_addr = batt_mode ? ADDR_W'(BOOT_BATT) : ADDR_W'(BOOT_XPDR);

endmodule

// File: rtl/vic_top.sv
module vic_top #(
   parameter int NSRC       = 5,
   parameter int ADDR_W     = 16,
   parameter int VEC_BASE   = 2,
   parameter int VEC_STRIDE = 2,
   parameter int BOOT_BATT  = 0,
   parameter int BOOT_XPDR  = 16,
   parameter bit HAS_NMI    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   irq,
   input  logic              cfg_we,
   input  logic [NSRC-1:0]   cfg_wdata,
   input  logic              sys_mode,
   input  logic              in_service,
   input  logic              batt_mode,
   output logic              take,
   output logic [ADDR_W-1:0] vec_addr,
   output logic [ADDR_W-1:0] boot_addr
);

   localparam int IDX_W    = $clog2(NSRC);
   localparam int LAST_VEC = vic_pkg::slot_addr(VEC_BASE, VEC_STRIDE, NSRC - 1);

   if (NSRC < 2 || NSRC > 16) begin : g_bad_nsrc
      $error("vic_top: NSRC must lie in 2..16");
   end
   if (VEC_STRIDE < 1) begin : g_bad_stride
      $error("vic_top: VEC_STRIDE must be at least 1");
   end
   if (ADDR_W < 4 || ADDR_W > 31 || LAST_VEC >= (1 << ADDR_W) ||
       BOOT_BATT >= (1 << ADDR_W) || BOOT_XPDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("vic_top: an address does not fit in ADDR_W bits");
   end

   logic [NSRC-1:0]  en_q;
   logic [NSRC-1:0]  pend_q;
   logic [NSRC-1:0]  grant;
   logic [IDX_W-1:0] gidx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (cfg_we) en_q <= cfg_wdata;
   end

   vic_pend #(.NSRC(NSRC)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .irq   (irq),
      .clr   (grant),
      .pend  (pend_q)
   );

   vic_arb #(.NSRC(NSRC), .HAS_NMI(HAS_NMI)) u_arb (
      .pend       (pend_q),
      .en         (en_q),
      .sys_mode   (sys_mode),
      .in_service (in_service),
      .take       (take),
      .grant      (grant),
      .gidx       (gidx)
   );

   vic_addr #(
      .NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE),
      .VEC_STRIDE(VEC_STRIDE), .BOOT_BATT(BOOT_BATT), .BOOT_XPDR(BOOT_XPDR)
   ) u_addr (
      .gidx      (gidx),
      .batt_mode (batt_mode),
      .vec_addr  (vec_addr),
      .boot_addr (boot_addr)
   );

endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
   parameter int NSRC       = 5,
   parameter int ADDR_W     = 16,
   parameter int VEC_BASE   = 2,
   parameter int VEC_STRIDE = 2,
   parameter int BOOT_BATT  = 0,
   parameter int BOOT_XPDR  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSRC-1:0]   irq,
   input logic              sys_mode,
   input logic              in_service,
   input logic              batt_mode,
   input logic [NSRC-1:0]   pend,
   input logic              take,
   input logic [ADDR_W-1:0] vec_addr,
   input logic [ADDR_W-1:0] boot_addr
);

   localparam int LAST = VEC_BASE + VEC_STRIDE * (NSRC - 1);

   logic [NSRC-1:0] irq_d;
   logic [NSRC-1:0] rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_d <= '1;
      else        irq_d <= irq;
   end
   assign rise = irq & ~irq_d;

   // R1: a pending bit only appears after a latched rising edge
   a_r1_set_by_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~$past(pend) & ~$past(rise)) == '0);

   // R3: a pending NMI outside system mode is taken at its own vector
   a_r3_nmi_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[0] && !sys_mode) |-> (take && vec_addr == ADDR_W'(VEC_BASE)));

   // R5: the vector shown always lies on a slot of the table
   a_r5_vec_slot: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (int'(vec_addr) >= VEC_BASE && int'(vec_addr) <= LAST &&
                ((int'(vec_addr) - VEC_BASE) % VEC_STRIDE) == 0));

   // R6: with no new edge, a take removes exactly one pending bit
   a_r6_one_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (take && rise == '0) |=> ($countones(pend) + 1 == $past($countones(pend))));

   // R7: system mode holds every source off
   a_r7_sys_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      sys_mode |-> !take);

   // R8: in-service lets only the NMI through
   a_r8_no_nesting: assert property (@(posedge clk) disable iff (!rst_n)
      (in_service && !pend[0]) |-> !take);

   // R9: start address follows the supply selector
   a_r9_boot: assert property (@(posedge clk) disable iff (!rst_n)
      boot_addr == (batt_mode ? ADDR_W'(BOOT_BATT) : ADDR_W'(BOOT_XPDR)));

endmodule

bind vic_top vic_chk #(
   .NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
   .BOOT_BATT(BOOT_BATT), .BOOT_XPDR(BOOT_XPDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq        (irq),
   .sys_mode   (sys_mode),
   .in_service (in_service),
   .batt_mode  (batt_mode),
   .pend       (pend_q),
   .take       (take),
   .vec_addr   (vec_addr),
   .boot_addr  (boot_addr)
);

// File: tb/vic_top_tb.sv
module vic_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 5;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq = '0;
   logic          cfg_we = 1'b0;
   logic [N-1:0]  cfg_wdata = '0;
   logic          sys_mode = 1'b0;
   logic          in_service = 1'b0;
   logic          batt_mode = 1'b1;
   logic          take;
   logic [AW-1:0] vec_addr;
   logic [AW-1:0] boot_addr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Bench model state
   logic [N-1:0] m_pend = '0;
   logic [N-1:0] m_en   = '0;
   logic [N-1:0] m_prev = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vic_top u_dut (
      .clk(clk), .rst_n(rst_n), .irq(irq), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .sys_mode(sys_mode), .in_service(in_service), .batt_mode(batt_mode),
      .take(take), .vec_addr(vec_addr), .boot_addr(boot_addr)
   );

   // Lowest eligible source, or -1
   function automatic int winner();
      if (sys_mode) return -1;
      if (m_pend[0]) return 0;
      if (in_service) return -1;
      for (int i = 1; i < N; i++) if (m_pend[i] && m_en[i]) return i;
      return -1;
   endfunction

   task automatic check_outputs(input string tag);
      int w = winner();
      n_chk++;
      if (take !== (w >= 0)) begin
         n_fail++;
         $display("FAIL %s take act=%0b exp=%0b pend=%b en=%b", tag, take, (w >= 0), m_pend, m_en);
      end else if (w >= 0 && vec_addr !== AW'(2 + 2 * w)) begin
         n_fail++;
         $display("FAIL %s vec act=%h exp=%h", tag, vec_addr, AW'(2 + 2 * w));
      end
   endtask

   // At a negedge: apply new inputs, model the edge, then check at the next negedge
   task automatic cycle(input logic [N-1:0] new_irq, input logic we, input logic [N-1:0] wd,
                        input logic sys, input logic isr, input string tag);
      logic [N-1:0] rise;
      int w;
      irq = new_irq; cfg_we = we; cfg_wdata = wd; sys_mode = sys; in_service = isr;
      rise = new_irq & ~m_prev;
      m_prev = new_irq;
      w = winner();
      if (w >= 0) m_pend[w] = 1'b0;
      m_pend = m_pend | rise;
      if (we) m_en = wd;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      check_outputs(tag);
   endtask

   task automatic drain(input logic [N-1:0] hold, input string tag);
      cycle(hold, 1'b1, '1, 1'b0, 1'b0, tag);
      for (int k = 0; k < N + 1; k++) cycle(hold, 1'b0, '1, 1'b0, 1'b0, tag);
      cycle('0, 1'b0, '0, 1'b0, 1'b0, tag);
   endtask

   initial begin
      // R1: a line held high through reset is not an edge
      irq = 5'b00100;
      m_prev = 5'b00100;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (take !== 1'b0) begin
         n_fail++; $display("FAIL R10 reset take act=%0b exp=0", take);
      end
      // R9: start address per supply
      n_chk++;
      if (boot_addr !== 16'h0000) begin
         n_fail++; $display("FAIL R9 boot act=%h exp=0000", boot_addr);
      end
      batt_mode = 1'b0;
      #1;
      n_chk++;
      if (boot_addr !== 16'h0010) begin
         n_fail++; $display("FAIL R9 boot act=%h exp=0010", boot_addr);
      end
      // R1/R2: enable all while line stays high: no take
      cycle(5'b00100, 1'b1, '1, 1'b0, 1'b0, "R1");
      cycle(5'b00100, 1'b0, '1, 1'b0, 1'b0, "R1");
      cycle('0, 1'b0, '0, 1'b0, 1'b0, "R2");

      // R2 R3 R4 R5 R6: every enable mask against every simultaneous request set
      for (int e = 0; e < 32; e++) begin
         for (int p = 1; p < 32; p++) begin
            cycle('0, 1'b1, N'(e), 1'b0, 1'b0, "R2");
            cycle(N'(p), 1'b0, '0, 1'b0, 1'b0, "R4");
            for (int k = 0; k < N + 1; k++) cycle(N'(p), 1'b0, '0, 1'b0, 1'b0, "R4");
            drain(N'(p), "R2");
         end
      end

      // R7 R8 R3: blocking inputs against every request set
      for (int s = 0; s < 2; s++) begin
         for (int i = 0; i < 2; i++) begin
            for (int p = 1; p < 32; p++) begin
               cycle('0, 1'b1, '1, s[0], i[0], "R8");
               cycle(N'(p), 1'b0, '0, s[0], i[0], s[0] ? "R7" : "R8");
               for (int k = 0; k < 3; k++) cycle(N'(p), 1'b0, '0, s[0], i[0], s[0] ? "R7" : "R3");
               drain(N'(p), "R7");
            end
         end
      end

      // R6: new edge on a source in the very cycle it is taken
      cycle('0, 1'b1, '1, 1'b0, 1'b1, "R6");
      cycle(5'b00010, 1'b0, '0, 1'b0, 1'b1, "R6");
      cycle('0, 1'b0, '0, 1'b0, 1'b1, "R6");
      cycle(5'b00010, 1'b0, '0, 1'b0, 1'b0, "R6");
      n_chk++;
      if (take !== 1'b1 || vec_addr !== 16'h0004) begin
         n_fail++;
         $display("FAIL R6 retake act=%0b/%h exp=1/0004", take, vec_addr);
      end
      cycle(5'b00010, 1'b0, '0, 1'b0, 1'b0, "R6");
      n_chk++;
      if (take !== 1'b0) begin
         n_fail++; $display("FAIL R6 cleared act=%0b exp=0", take);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule